// File: doc/BRIEF.md
# Master Clock Selector and Prescaler

This block generates the system master clock. It chooses one of three free-running input clocks (a slow clock, a main oscillator clock and a PLL clock) and divides the chosen clock by a power of two between 1 and 64. Source and division live together in one control register written through a small synchronous register port on a separate configuration clock. Every change runs through a stop-then-start sequence, so the output never carries a runt pulse, whichever settings are involved.

A ready flag in the status register drops on each control write. It returns to 1 only after the new source is gated through and the divided clock has completed a full period. An interrupt enable turns that flag into a level-sensitive interrupt request. A second output, the processor clock, follows the master clock and is held low while an idle request is active. Logic that has to keep running, such as interrupt handling and memory control, takes the master clock directly.

Top module: `mck_ctrl`

## Requirements
- R1: Control field `src` at bits [1:0] of address 0 picks the source: 2'b00 slow, 2'b01 main, 2'b11 PLL. Once ready, the `mck` period equals the selected input's period times the division.
- R2: Control field `div` at bits [6:4] of address 0 with value n (0..6) divides by 2^n. Reading address 0 returns the stored `src` and `div` fields at the same positions.
- R3: A `src` write of 2'b10 keeps the previously requested source while the `div` field still applies. A `div` value of 7 divides by 1.
- R4: Every write to address 0 clears `mck_rdy` on the following configuration clock edge, even when the value written equals the current one.
- R5: `mck_rdy` stays 0 until the new source is enabled and at least one full divided period has passed, so the time from the write to ready is at least one new output period. Once set, it stays 1 until the next write to address 0.
- R6: At most one source is gated through at any time. No high or low phase of `mck` is shorter than the shortest input half-period, including during a switch.
- R7: Status bit 0 at address 1 reads `mck_rdy`. Interrupt enable is bit 0 at address 2. `irq` is high exactly while both are 1, drops with the ready flag and rises again when ready returns.
- R8: `pck` follows `mck` while `idle_req` is 0 and is held low while `idle_req` is 1, while `mck` keeps running.
- R9: After reset the slow clock is selected with divide by 1, `mck_rdy` is 1, the interrupt enable is 0 and address 0 reads 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| cfg_clk | input | 1 | Configuration and register clock |
| rst_n | input | 1 | Synchronous active-low reset, held for several cycles of every clock |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data, combinational from `reg_addr` |
| clk_slow | input | 1 | Slow input clock |
| clk_main | input | 1 | Main oscillator input clock |
| clk_pll | input | 1 | PLL input clock |
| idle_req | input | 1 | Idle request that stops the processor clock |
| mck | output | 1 | Master clock |
| pck | output | 1 | Processor clock, gated master clock |
| mck_rdy | output | 1 | Master clock ready flag |
| irq | output | 1 | Level interrupt request on ready |

## Verification
A corrupted enable chain or sequencer state shows at the ports as a wrong `mck` period, or as a runt phase when two sources overlap, from the first output edge after the switch. A stuck sequencer keeps `mck_rdy` and `irq` low for good, and a sequencer that skips the settle step raises ready sooner than one new output period after the write. Both are visible within a few output periods. An idle gate that is out of step shows as `pck` edges during idle, or as no `pck` edges once idle has been released.

// File: rtl/mck_pkg.sv
// Package: shared constants, field encodings and state type of the master clock block.
// Assumes exactly three clock sources, in the fixed order slow, main, PLL.
package mck_pkg;
    localparam int NUM_SRC      = 3;
    localparam int LOG2_DIV_MAX = 6;
    localparam int DIV_W        = 3;
    localparam int REG_W        = 8;
    localparam int ADDR_W       = 2;
    localparam int SYNC_STAGES  = 2;

    localparam logic [ADDR_W-1:0] ADDR_CTRL = 2'd0;
    localparam logic [ADDR_W-1:0] ADDR_STAT = 2'd1;
    localparam logic [ADDR_W-1:0] ADDR_IEN  = 2'd2;

    typedef enum logic [1:0] {
        SRC_SLOW = 2'b00,
        SRC_MAIN = 2'b01,
        SRC_RSVD = 2'b10,
        SRC_PLL  = 2'b11
    } src_code_e;

    typedef enum logic [1:0] {
        ST_READY,
        ST_STOP,
        ST_START,
        ST_SETTLE
    } seq_state_e;

    // Maps a source code to its one-hot enable request (bit 0 slow, 1 main, 2 PLL).
    function automatic logic [NUM_SRC-1:0] src_onehot(input logic [1:0] code);
        case (code)
            SRC_MAIN: return 3'b010;
            SRC_PLL:  return 3'b100;
            default:  return 3'b001;
        endcase
    endfunction
endpackage

// File: rtl/mck_src_gate.sv
// Module: enable chain of one clock source for the glitch-free selector.
// The request (already masked by the other sources' enables) passes a
// synchronizer on the source's rising edge; the enable changes on the falling
// edge, so the gated clock only switches while the source is low.
// Assumes the source clock runs during reset.
module mck_src_gate #(
    parameter int SYNC_STAGES = 2,
    parameter bit RESET_ON    = 1'b0
) (
    input  logic clk_src,
    input  logic rst_n,
    input  logic req,
    input  logic others_on,
    output logic en,
    output logic active
);
    logic [SYNC_STAGES-1:0] sync_q;
    logic                   en_q;

    // Bring the masked request into this source's domain.
    always_ff @(posedge clk_src) begin
        if (!rst_n) sync_q <= {SYNC_STAGES{RESET_ON}};
        else        sync_q <= {sync_q[SYNC_STAGES-2:0], req & ~others_on};
    end

    // Update the enable only while the source is low.
    always_ff @(negedge clk_src) begin
        if (!rst_n) en_q <= RESET_ON;
        else        en_q <= sync_q[SYNC_STAGES-1];
    end

    assign en     = en_q;
    assign active = (|sync_q) | en_q;
endmodule

// File: rtl/mck_divider.sv
// Module: power-of-two prescaler on the gated source clock.
// Output is the input itself for a shift of 0, otherwise one bit of a
// free-running counter, so every phase lasts whole input periods. A toggle
// flips once per divided period so that another domain can observe progress.
// Assumes div_log2 only changes while the input clock is stopped.
module mck_divider #(
    parameter int LOG2_MAX = 6,
    parameter int DIV_W    = 3
) (
    input  logic             clk_in,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] div_log2,
    output logic             clk_out,
    output logic             wrap_tgl
);
    localparam int CW = LOG2_MAX;

    logic [CW-1:0] cnt_q;
    logic [CW-1:0] wrap_mask;
    logic          tgl_q;

    assign wrap_mask = CW'((32'd1 << div_log2) - 32'd1);

    // Count input periods and flip the toggle at the end of each divided period.
    always_ff @(posedge clk_in) begin
        if (!rst_n) begin
            cnt_q <= '0;
            tgl_q <= 1'b0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
            if ((cnt_q & wrap_mask) == wrap_mask) tgl_q <= ~tgl_q;
        end
    end

    // Pick the pass-through clock or the counter bit that matches the shift.
    always_comb begin
        if (div_log2 == '0) clk_out = clk_in;
        else                clk_out = cnt_q[div_log2 - 1'b1];
    end

    assign wrap_tgl = tgl_q;
endmodule

// File: rtl/mck_pck_gate.sv
// Module: processor clock gate. The idle request is synchronized on the master
// clock and the gate enable changes on its falling edge, so the gated output
// never carries a shortened high phase.
// Assumes the master clock runs during reset.
module mck_pck_gate #(
    parameter int SYNC_STAGES = 2
) (
    input  logic mck,
    input  logic rst_n,
    input  logic idle_req,
    output logic pck
);
    logic [SYNC_STAGES-1:0] idle_sync_q;
    logic                   run_q;

    // Synchronize the idle request into the master clock domain.
    always_ff @(posedge mck) begin
        if (!rst_n) idle_sync_q <= '0;
        else        idle_sync_q <= {idle_sync_q[SYNC_STAGES-2:0], idle_req};
    end

    // Change the gate enable while the master clock is low.
    always_ff @(negedge mck) begin
        if (!rst_n) run_q <= 1'b1;
        else        run_q <= ~idle_sync_q[SYNC_STAGES-1];
    end

    assign pck = mck & run_q;
endmodule

// File: rtl/mck_seq.sv
// Module: register file and switch sequencer on the configuration clock.
// A control write clears ready and withdraws all source requests. Once every
// enable chain has drained, it applies the new division and requests the new
// source, waits for that source's enable, then waits for two progress toggles
// of the divider before raising ready.
// Assumes the source-side vectors are asynchronous and synchronizes them here.
module mck_seq
    import mck_pkg::*;
#(
    parameter int N_SRC  = NUM_SRC,
    parameter int DW     = DIV_W,
    parameter int RW     = REG_W,
    parameter int AW     = ADDR_W,
    parameter int STAGES = SYNC_STAGES
) (
    input  logic             cfg_clk,
    input  logic             rst_n,
    input  logic             reg_we,
    input  logic [AW-1:0]    reg_addr,
    input  logic [RW-1:0]    reg_wdata,
    output logic [RW-1:0]    reg_rdata,
    input  logic [N_SRC-1:0] act_vec,
    input  logic [N_SRC-1:0] en_vec,
    input  logic             wrap_tgl,
    output logic [N_SRC-1:0] req_vec,
    output logic [DW-1:0]    div_apply,
    output logic             mck_rdy,
    output logic             irq,
    output logic             irq_en
);
    localparam int HOLD   = STAGES + 1;
    localparam int HOLD_W = $clog2(HOLD + 1);

    logic [STAGES-1:0][N_SRC-1:0] act_pipe, en_pipe;
    logic [STAGES-1:0]            tgl_pipe;
    logic [N_SRC-1:0]             act_s, en_s;
    logic                         tgl_s;
    logic [1:0]                   tgt_src;
    logic [DW-1:0]                tgt_div;
    logic                         ie_q, rdy_q, tgl_ref;
    logic [N_SRC-1:0]             req_q;
    logic [DW-1:0]                div_q;
    logic [HOLD_W-1:0]            hold_cnt;
    logic                         edge_seen;
    seq_state_e                   state;
    logic                         ctrl_wr;
    logic                         unused_wdata_bits;

    assign ctrl_wr           = reg_we && (reg_addr == ADDR_CTRL);
    assign unused_wdata_bits = ^{reg_wdata[RW-1:7], reg_wdata[3:2]};
    assign act_s             = act_pipe[STAGES-1];
    assign en_s              = en_pipe[STAGES-1];
    assign tgl_s             = tgl_pipe[STAGES-1];

    // Synchronize source-side status into the configuration domain.
    always_ff @(posedge cfg_clk) begin
        if (!rst_n) begin
            act_pipe <= '0;
            en_pipe  <= '0;
            tgl_pipe <= '0;
        end else begin
            act_pipe <= {act_pipe[STAGES-2:0], act_vec};
            en_pipe  <= {en_pipe[STAGES-2:0], en_vec};
            tgl_pipe <= {tgl_pipe[STAGES-2:0], wrap_tgl};
        end
    end

    // Hold the interrupt enable register.
    always_ff @(posedge cfg_clk) begin
        if (!rst_n)                             ie_q <= 1'b0;
        else if (reg_we && reg_addr == ADDR_IEN) ie_q <= reg_wdata[0];
    end

    // Accept control writes and step the stop, apply, start and settle sequence.
    always_ff @(posedge cfg_clk) begin
        if (!rst_n) begin
            tgt_src   <= SRC_SLOW;
            tgt_div   <= '0;
            req_q     <= src_onehot(SRC_SLOW);
            div_q     <= '0;
            rdy_q     <= 1'b1;
            state     <= ST_READY;
            hold_cnt  <= '0;
            tgl_ref   <= 1'b0;
            edge_seen <= 1'b0;
        end else if (ctrl_wr) begin
            if (reg_wdata[1:0] != SRC_RSVD) tgt_src <= reg_wdata[1:0];
            tgt_div  <= reg_wdata[6:4];
            req_q    <= '0;
            rdy_q    <= 1'b0;
            hold_cnt <= '0;
            state    <= ST_STOP;
        end else begin
            case (state)
                ST_STOP: begin
                    if (hold_cnt != HOLD_W'(HOLD)) begin
                        hold_cnt <= hold_cnt + 1'b1;
                    end else if (act_s == '0) begin
                        div_q <= (tgt_div == '1) ? '0 : tgt_div;
                        req_q <= src_onehot(tgt_src);
                        state <= ST_START;
                    end
                end
                ST_START: begin
                    if ((en_s & req_q) != '0) begin
                        tgl_ref   <= tgl_s;
                        edge_seen <= 1'b0;
                        state     <= ST_SETTLE;
                    end
                end
                ST_SETTLE: begin
                    if (tgl_s != tgl_ref) begin
                        tgl_ref <= tgl_s;
                        if (edge_seen) begin
                            rdy_q <= 1'b1;
                            state <= ST_READY;
                        end else begin
                            edge_seen <= 1'b1;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    // Return the addressed register.
    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            ADDR_CTRL: begin
                reg_rdata[1:0] = tgt_src;
                reg_rdata[6:4] = tgt_div;
            end
            ADDR_STAT: reg_rdata[0] = rdy_q;
            ADDR_IEN:  reg_rdata[0] = ie_q;
            default:   reg_rdata = '0;
        endcase
    end

    assign req_vec   = req_q;
    assign div_apply = div_q;
    assign mck_rdy   = rdy_q;
    assign irq_en    = ie_q;
    assign irq       = rdy_q & ie_q;
endmodule

// File: rtl/mck_ctrl.sv
// Module: top of the master clock selector. It instantiates one enable chain
// per source, ORs the gated sources, divides the result, gates the processor
// clock and hosts the register sequencer.
// Assumes all input clocks run freely, and for some cycles during reset.
module mck_ctrl
    import mck_pkg::*;
(
    input  logic              cfg_clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [REG_W-1:0]  reg_wdata,
    output logic [REG_W-1:0]  reg_rdata,
    input  logic              clk_slow,
    input  logic              clk_main,
    input  logic              clk_pll,
    input  logic              idle_req,
    output logic              mck,
    output logic              pck,
    output logic              mck_rdy,
    output logic              irq
);
    logic [NUM_SRC-1:0] clk_vec, en_vec, act_vec, req_vec;
    logic [DIV_W-1:0]   div_apply;
    logic               sel_clk, wrap_tgl, irq_en;

    assign clk_vec = {clk_pll, clk_main, clk_slow};

    // One enable chain per source, each masked by the others' enables.
    for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
        logic [NUM_SRC-1:0] own_bit;
        assign own_bit = NUM_SRC'(1) << i;
        mck_src_gate #(
            .SYNC_STAGES(SYNC_STAGES),
            .RESET_ON   (i == 0)
        ) u_gate (
            .clk_src  (clk_vec[i]),
            .rst_n    (rst_n),
            .req      (req_vec[i]),
            .others_on(|(en_vec & ~own_bit)),
            .en       (en_vec[i]),
            .active   (act_vec[i])
        );
    end

    assign sel_clk = |(clk_vec & en_vec);

    mck_divider #(
        .LOG2_MAX(LOG2_DIV_MAX),
        .DIV_W   (DIV_W)
    ) u_div (
        .clk_in  (sel_clk),
        .rst_n   (rst_n),
        .div_log2(div_apply),
        .clk_out (mck),
        .wrap_tgl(wrap_tgl)
    );

    mck_pck_gate #(
        .SYNC_STAGES(SYNC_STAGES)
    ) u_pck (
        .mck     (mck),
        .rst_n   (rst_n),
        .idle_req(idle_req),
        .pck     (pck)
    );

    mck_seq u_seq (
        .cfg_clk  (cfg_clk),
        .rst_n    (rst_n),
        .reg_we   (reg_we),
        .reg_addr (reg_addr),
        .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata),
        .act_vec  (act_vec),
        .en_vec   (en_vec),
        .wrap_tgl (wrap_tgl),
        .req_vec  (req_vec),
        .div_apply(div_apply),
        .mck_rdy  (mck_rdy),
        .irq      (irq),
        .irq_en   (irq_en)
    );
endmodule

// File: rtl/mck_ctrl_chk.sv
// Module: protocol checker bound to the master clock top, sampled on the
// configuration clock.
module mck_ctrl_chk
    import mck_pkg::*;
(
    input logic              cfg_clk,
    input logic              rst_n,
    input logic              reg_we,
    input logic [ADDR_W-1:0] reg_addr,
    input logic [NUM_SRC-1:0] en_vec,
    input logic              mck_rdy,
    input logic              irq,
    input logic              irq_en
);
    logic ctrl_wr;
    assign ctrl_wr = reg_we && (reg_addr == ADDR_CTRL);

    AST_ONE_SOURCE: assert property (@(posedge cfg_clk) disable iff (!rst_n)
        $onehot0(en_vec)); // R6
    AST_WRITE_DROPS_READY: assert property (@(posedge cfg_clk) disable iff (!rst_n)
        ctrl_wr |=> !mck_rdy); // R4
    AST_READY_HELD: assert property (@(posedge cfg_clk) disable iff (!rst_n)
        (mck_rdy && !ctrl_wr) |=> mck_rdy); // R5
    AST_READY_HAS_SOURCE: assert property (@(posedge cfg_clk) disable iff (!rst_n)
        mck_rdy |-> (en_vec != '0)); // R5
    AST_IRQ_NEEDS_READY: assert property (@(posedge cfg_clk) disable iff (!rst_n)
        irq |-> mck_rdy); // R7
    AST_IRQ_MASKED: assert property (@(posedge cfg_clk) disable iff (!rst_n)
        !irq_en |-> !irq); // R7
endmodule

bind mck_ctrl mck_ctrl_chk u_chk (
    .cfg_clk (cfg_clk),
    .rst_n   (rst_n),
    .reg_we  (reg_we),
    .reg_addr(reg_addr),
    .en_vec  (en_vec),
    .mck_rdy (mck_rdy),
    .irq     (irq),
    .irq_en  (irq_en)
);

// File: tb/mck_ctrl_test.sv
`timescale 1ns/1ps
// Bench: directed scenarios, one task each, on a 250 MHz configuration clock.
module mck_ctrl_test;
    localparam real PER_SLOW = 50.0;
    localparam real PER_MAIN = 16.0;
    localparam real PER_PLL  = 10.0;
    localparam real MIN_HALF = 5.0;

    logic       cfg_clk = 0, clk_slow = 0, clk_main = 0, clk_pll = 0;
    logic       rst_n = 0, reg_we = 0, idle_req = 0;
    logic [1:0] reg_addr = 0;
    logic [7:0] reg_wdata = 0;
    logic [7:0] reg_rdata;
    logic       mck, pck, mck_rdy, irq;

    int n_chk = 0;
    int n_fail = 0;
    int short_cnt = 0;
    realtime last_edge = 0.0;
    bit have_edge = 0;

    always #2.0  cfg_clk  = ~cfg_clk;
    always #25.0 clk_slow = ~clk_slow;
    always #8.0  clk_main = ~clk_main;
    always #5.0  clk_pll  = ~clk_pll;

    mck_ctrl uut (
        .cfg_clk(cfg_clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .clk_slow(clk_slow),
        .clk_main(clk_main), .clk_pll(clk_pll), .idle_req(idle_req),
        .mck(mck), .pck(pck), .mck_rdy(mck_rdy), .irq(irq)
    );

    // Runt monitor: every mck phase after reset must last at least MIN_HALF (R6).
    always @(mck) begin
        if (rst_n === 1'b1 && !$isunknown(mck)) begin
            if (have_edge && ($realtime - last_edge) < MIN_HALF - 0.01) short_cnt++;
            last_edge = $realtime;
            have_edge = 1;
        end
    end

    task automatic chk_int(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic chk_real(input string tag, input real act, input real exp);
        n_chk++;
        if (act < exp - 0.01 || act > exp + 0.01) begin
            n_fail++;
            $display("FAIL %s: actual %0.3f expected %0.3f", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge cfg_clk);
        reg_we = 1; reg_addr = a; reg_wdata = d;
        @(negedge cfg_clk);
        reg_we = 0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        @(negedge cfg_clk);
        reg_addr = a;
        #0.5;
        d = reg_rdata;
    endtask

    task automatic wait_rdy(output int ok);
        ok = 0;
        for (int i = 0; i < 40000; i++) begin
            @(negedge cfg_clk);
            if (mck_rdy === 1'b1) begin ok = 1; break; end
        end
    endtask

    task automatic meas_mck(output real per);
        realtime t1;
        @(posedge mck);
        @(posedge mck);
        t1 = $realtime;
        @(posedge mck);
        per = $realtime - t1;
    endtask

    function automatic real src_per(input int code);
        if (code == 0) return PER_SLOW;
        if (code == 1) return PER_MAIN;
        return PER_PLL;
    endfunction

    task automatic t_reset();
        logic [7:0] d;
        real p;
        chk_int("R9 ready after reset", int'(mck_rdy), 1);
        chk_int("R9 irq after reset", int'(irq), 0);
        rd(2'd0, d); chk_int("R9 ctrl readback", int'(d), 0);
        rd(2'd2, d); chk_int("R9 irq enable reset", int'(d), 0);
        rd(2'd1, d); chk_int("R7 status bit", int'(d), 1);
        meas_mck(p); chk_real("R9 slow div1 period", p, PER_SLOW);
    endtask

    task automatic t_combos();
        int codes[3] = '{0, 1, 3};
        int ok;
        real p, exp_p;
        realtime t_wr;
        logic [7:0] d;
        for (int s = 0; s < 3; s++) begin
            for (int n = 0; n <= 6; n++) begin
                exp_p = src_per(codes[s]) * real'(1 << n);
                wr(2'd0, 8'((n << 4) | codes[s]));
                t_wr = $realtime;
                chk_int("R4 ready drops on write", int'(mck_rdy), 0);
                wait_rdy(ok);
                chk_int("R5 ready returns", ok, 1);
                if (ok == 1) begin
                    if ($realtime - t_wr < exp_p) begin
                        n_chk++; n_fail++;
                        $display("FAIL R5 ready too early: actual %0.3f expected >= %0.3f",
                                 $realtime - t_wr, exp_p);
                    end else n_chk++;
                    meas_mck(p);
                    chk_real("R1 R2 period", p, exp_p);
                end
                rd(2'd0, d);
                chk_int("R2 ctrl readback", int'(d), (n << 4) | codes[s]);
            end
        end
        chk_int("R6 no runt during sweeps", short_cnt, 0);
    endtask

    task automatic t_same_write();
        logic [7:0] d;
        int ok;
        wr(2'd0, 8'h63);
        chk_int("R4 same value clears ready", int'(mck_rdy), 0);
        rd(2'd1, d); chk_int("R4 status pending", int'(d[0]), 0);
        wait_rdy(ok); chk_int("R4 ready after same write", ok, 1);
    endtask

    task automatic t_reserved();
        logic [7:0] d;
        int ok;
        real p;
        wr(2'd0, 8'h13); wait_rdy(ok);
        wr(2'd0, 8'h22); wait_rdy(ok);
        chk_int("R3 ready after reserved src", ok, 1);
        meas_mck(p); chk_real("R3 reserved src keeps pll", p, PER_PLL * 4.0);
        rd(2'd0, d); chk_int("R3 readback keeps src", int'(d), 8'h23);
        wr(2'd0, 8'h71); wait_rdy(ok);
        meas_mck(p); chk_real("R3 div 7 is divide by 1", p, PER_MAIN);
        rd(2'd0, d); chk_int("R3 readback div 7", int'(d), 8'h71);
    endtask

    task automatic t_irq();
        int ok;
        wr(2'd2, 8'h00);
        chk_int("R7 irq masked", int'(irq), 0);
        wr(2'd2, 8'h01);
        chk_int("R7 irq when ready and enabled", int'(irq), 1);
        wr(2'd0, 8'h01);
        chk_int("R7 irq drops with ready", int'(irq), 0);
        wait_rdy(ok);
        chk_int("R7 irq returns with ready", int'(irq), 1);
        wr(2'd2, 8'h00);
        chk_int("R7 irq off after disable", int'(irq), 0);
    endtask

    task automatic t_idle();
        int pck_hi, mck_tog;
        logic prev;
        real p;
        realtime t1;
        @(negedge cfg_clk); idle_req = 1;
        repeat (4) @(posedge mck);
        pck_hi = 0; mck_tog = 0; prev = mck;
        for (int i = 0; i < 200; i++) begin
            @(negedge cfg_clk);
            if (pck === 1'b1) pck_hi++;
            if (mck !== prev) mck_tog++;
            prev = mck;
        end
        chk_int("R8 pck held low in idle", pck_hi, 0);
        chk_int("R8 mck runs in idle", int'(mck_tog > 10), 1);
        @(negedge cfg_clk); idle_req = 0;
        repeat (4) @(posedge mck);
        @(posedge pck); t1 = $realtime;
        @(posedge pck); p = $realtime - t1;
        chk_real("R8 pck follows mck", p, PER_MAIN);
    endtask

    initial begin
        #400000.0;
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (150) @(negedge cfg_clk);
        rst_n = 1;
        repeat (4) @(negedge cfg_clk);
        t_reset();
        t_combos();
        t_same_write();
        t_reserved();
        t_irq();
        t_idle();
        chk_int("R6 no runt overall", short_cnt, 0);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule